// File: doc/BRIEF.md
# Single-Channel Waveform Generator with Selectable Clock and Alignment

This block produces one pulse-width-modulated output from the master clock. A source selector gives a counting tick. The tick comes either from a power-of-two prescale of the master clock or from one of two linear dividers with an 8-bit ratio. A period counter advances on each tick. Its value is compared with an active duty value, and the result drives the output pin. A polarity bit sets the level at the start of each period. The counter either wraps after one pass (left aligned) or climbs and then descends (center aligned). The center-aligned mode doubles the period and places the duty window symmetrically about the period midpoint.

Software writes mode, period, duty and divider ratios through a small write port. Period and duty writes made while the channel runs go to holding registers. They are copied to the active registers only at a period boundary, so the output never shows a truncated or glitched pulse. When the channel enable is low, the counter and dividers rest at zero and the pin sits at its inactive level.

Top module: `pwm_chan_gen`

## Requirements
- R1: The write port has four addresses. Address 0 holds the mode: bits [3:0] source, bit 4 center alignment, bit 5 start polarity. Address 1 holds the period, address 2 the duty, and address 3 the divider ratios (bits [7:0] divider A, bits [15:8] divider B). A source value s from 0 to 10 makes one tick every 2^s master-clock cycles, so a left-aligned period lasts 2^s × period cycles.
- R2: Source 11 takes its tick from divider A and source 12 from divider B. A divider with ratio N gives one tick every N master-clock cycles.
- R3: A divider ratio of 0 stops that divider, so a channel using it never advances and its output holds the level of counter value zero.
- R4: In left-aligned mode the counter runs 0 up to period−1 and then wraps. The output shows the start level while the counter is below the duty value and the inverse level otherwise. A period value of 0 acts as 1.
- R5: In center-aligned mode the counter runs up 0..period−1 and then down period−1..0, for a period of 2 × period ticks. The start level is shown for the first duty ticks and the last duty ticks of each period.
- R6: Polarity 1 starts each period high and polarity 0 starts it low. Reset leaves polarity 0, left alignment and source 0.
- R7: Duty 0 holds the inverse level for the whole period. Duty equal to or above the period holds the start level for the whole period.
- R8: Period and duty writes made while enabled take effect at the next period boundary and not before. While disabled they take effect at once.
- R9: With enable low the counter is cleared and the output is the inverse of the polarity bit. After enable rises, the first period begins at counter value zero, and the first tick arrives after one full tick interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 mode, 1 period, 2 duty, 3 dividers) |
| wr_data | input | 16 | Register write data |
| ch_en | input | 1 | Channel enable |
| wave | output | 1 | Waveform output |

## Verification
The hardest situation to reach is a write landing in the holding registers in the middle of a running period. Both the old and the new values must then be seen on the pin, on opposite sides of the exact boundary edge. The bench reaches it by issuing the duty write and then the period write on chosen cycles inside the second period of a running left-aligned waveform. It then predicts each cycle with the old settings up to the boundary and the new ones after it. Dividers with a zero ratio and the slowest prescale tap are also covered by sampling every cycle against a closed-form model of tick count and counter phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Register addresses of the write port
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_DUTY   = 2'd2;
  localparam logic [1:0] ADDR_DIV    = 2'd3;

  localparam int SRC_W = 4;

  // Mode fields in bit order of the mode register
  typedef struct packed {
    logic             pol;     // bit 5: start level
    logic             center;  // bit 4: center alignment
    logic [SRC_W-1:0] src;     // bits 3:0: tick source
  } mode_t;

  localparam mode_t MODE_RESET = '{pol: 1'b0, center: 1'b0, src: '0};

endpackage

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             live;

  assign live = run && (ratio != '0);
  assign tick = live && (cnt_q == ratio - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!live)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DIV_W = 8,
  parameter int PRE_N = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [pwm_pkg::SRC_W-1:0] src,
  input  logic [DIV_W-1:0]        div_a,
  input  logic [DIV_W-1:0]        div_b,
  output logic                    tick
);
  localparam int PC_W   = PRE_N - 1;
  localparam int N_LIN  = 2;

  logic [PC_W-1:0]  pc_q;
  logic [PRE_N-1:0] tap;
  logic [N_LIN-1:0] lin_tick;
  logic [DIV_W-1:0] ratio [N_LIN];

  assign ratio[0] = div_a;
  assign ratio[1] = div_b;

  // Free-running prescale counter, held at zero while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (!run) pc_q <= '0;
    else           pc_q <= pc_q + PC_W'(1);
  end

  // Tap k fires once every 2^k cycles
  for (genvar k = 0; k < PRE_N; k++) begin : g_tap
    if (k == 0) begin : g_first
      assign tap[k] = 1'b1;
    end else begin : g_rest
      assign tap[k] = &pc_q[k-1:0];
    end
  end

  for (genvar d = 0; d < N_LIN; d++) begin : g_lin
    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .ratio (ratio[d]),
      .tick  (lin_tick[d])
    );
  end

  always_comb begin
    tick = 1'b0;
    if (run) begin
      if (int'(src) < PRE_N)           tick = tap[src];
      else if (int'(src) == PRE_N)     tick = lin_tick[0];
      else if (int'(src) == PRE_N + 1) tick = lin_tick[1];
      else                             tick = 1'b0;
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] period_sh,
  input  logic [CNT_W-1:0] duty_sh,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             boundary,
  output logic [CNT_W-1:0] period_act,
  output logic [CNT_W-1:0] duty_act
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Period of zero behaves as one
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  logic [CNT_W-1:0] top_val;
  logic             at_top;

  assign top_val  = eff_period(period_act) - ONE;
  assign at_top   = (cnt >= top_val);
  assign boundary = run && tick && (center ? (dir_down && cnt == '0) : at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      dir_down   <= 1'b0;
      period_act <= '0;
      duty_act   <= '0;
    end else if (!run) begin
      cnt        <= '0;
      dir_down   <= 1'b0;
      period_act <= period_sh;
      duty_act   <= duty_sh;
    end else if (tick) begin
      if (boundary) begin
        cnt        <= '0;
        dir_down   <= 1'b0;
        period_act <= period_sh;
        duty_act   <= duty_sh;
      end else if (!center) begin
        cnt      <= cnt + ONE;
        dir_down <= 1'b0;
      end else if (!dir_down) begin
        if (at_top) dir_down <= 1'b1;
        else        cnt      <= cnt + ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen #(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int PRE_N  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ch_en,
  output logic              wave
);
  import pwm_pkg::*;

  localparam int MODE_W = $bits(mode_t);

  mode_t            mode_q;
  logic [CNT_W-1:0] period_sh;
  logic [CNT_W-1:0] duty_sh;
  logic [DIV_W-1:0] div_a;
  logic [DIV_W-1:0] div_b;
  logic             unused_wr_bits;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             dir_down;
  logic             boundary;
  logic [CNT_W-1:0] period_act;
  logic [CNT_W-1:0] duty_act;

  assign unused_wr_bits = ^wr_data[DATA_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RESET;
      period_sh <= '0;
      duty_sh   <= '0;
      div_a     <= '0;
      div_b     <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_MODE:   mode_q    <= mode_t'(wr_data[MODE_W-1:0]);
        ADDR_PERIOD: period_sh <= wr_data[CNT_W-1:0];
        ADDR_DUTY:   duty_sh   <= wr_data[CNT_W-1:0];
        ADDR_DIV: begin
          div_a <= wr_data[DIV_W-1:0];
          div_b <= wr_data[2*DIV_W-1:DIV_W];
        end
        default: ;
      endcase
    end
  end

  pwm_tick_gen #(.DIV_W(DIV_W), .PRE_N(PRE_N)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ch_en),
    .src   (mode_q.src),
    .div_a (div_a),
    .div_b (div_b),
    .tick  (tick)
  );

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ch_en),
    .tick       (tick),
    .center     (mode_q.center),
    .period_sh  (period_sh),
    .duty_sh    (duty_sh),
    .cnt        (cnt),
    .dir_down   (dir_down),
    .boundary   (boundary),
    .period_act (period_act),
    .duty_act   (duty_act)
  );

  // Start level inside the duty window, inverse outside, inactive when stopped
  assign wave = ch_en ? ((cnt < duty_act) ? mode_q.pol : ~mode_q.pol) : ~mode_q.pol;
endmodule

// File: rtl/pwm_chan_sva.sv
module pwm_chan_sva #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter int PRE_N = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_en,
  input logic             wave,
  input logic             pol,
  input logic             center,
  input logic [3:0]       src,
  input logic [DIV_W-1:0] div_a,
  input logic [DIV_W-1:0] div_b,
  input logic             tick,
  input logic             boundary,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_down,
  input logic [CNT_W-1:0] period_act,
  input logic [CNT_W-1:0] duty_act
);
  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> wave == ~pol);

  a_r3_zero_ratio_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(src) == PRE_N && div_a == '0) || (int'(src) == PRE_N + 1 && div_b == '0)) |-> !tick);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && !$past(tick)) |-> cnt == $past(cnt));

  a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && !$past(boundary)) |-> ($stable(duty_act) && $stable(period_act)));

  a_r4_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && $past(tick) && !$past(center) && !$past(boundary))
      |-> cnt == $past(cnt) + 1'b1);

  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en |-> (cnt == '0 || cnt < period_act));

  a_r5_turn_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && $past(center) && center && !$past(dir_down) && dir_down)
      |-> cnt == $past(cnt));

  a_r9_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en) |-> (cnt == '0 && !dir_down));
endmodule

bind pwm_chan_gen pwm_chan_sva #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRE_N(PRE_N)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .wave       (wave),
  .pol        (mode_q.pol),
  .center     (mode_q.center),
  .src        (mode_q.src),
  .div_a      (div_a),
  .div_b      (div_b),
  .tick       (tick),
  .boundary   (boundary),
  .cnt        (cnt),
  .dir_down   (dir_down),
  .period_act (period_act),
  .duty_act   (duty_act)
);

// File: tb/pwm_chan_gen_tb.sv
module pwm_chan_gen_tb;
  localparam time CYC = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ch_en = 1'b0;
  logic        wave;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CYC/2) clk = ~clk;

  pwm_chan_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_en(ch_en), .wave(wave)
  );

  // Expected level in cycle i after enable, from tick count and counter phase
  function automatic logic model(int i, int x, int p, int d, logic pol, logic ctr);
    int k;
    int pe;
    int v;
    int ph;
    k  = i / x;
    pe = (p == 0) ? 1 : p;
    if (!ctr) v = k % pe;
    else begin
      ph = k % (2 * pe);
      v  = (ph < pe) ? ph : 2 * pe - 1 - ph;
    end
    return (v < d) ? pol : ~pol;
  endfunction

  task automatic check(string tag, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: wave=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mode_word(int src, logic ctr, logic pol);
    return {10'd0, pol, ctr, 4'(src)};
  endfunction

  // Configure, enable, compare every cycle, then disable
  task automatic run_check(string tag, int src, logic ctr, logic pol,
                           int p, int d, int x, int ncyc);
    ch_en = 1'b0;
    wr(2'd0, mode_word(src, ctr, pol));
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(d));
    @(posedge clk); #2 ch_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(tag, wave, model(i, x, p, d, pol, ctr));
    end
    ch_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 reset idle level", wave, 1'b1);
    // R6: reset mode is left aligned, polarity low, source 0
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd2);
    @(posedge clk); #2 ch_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R6 reset defaults", wave, model(i, 1, 4, 2, 1'b0, 1'b0));
    end
    ch_en = 1'b0;
  endtask

  task automatic t_prescale;
    run_check("R1 R4 src0", 0, 1'b0, 1'b1, 4, 1, 1, 16);
    run_check("R1 R4 src3", 3, 1'b0, 1'b1, 5, 2, 8, 120);
    run_check("R1 src10",  10, 1'b0, 1'b1, 2, 1, 1024, 4200);
  endtask

  task automatic t_center;
    run_check("R5 center src1", 1, 1'b1, 1'b1, 3, 1, 2, 40);
    run_check("R5 center src0", 0, 1'b1, 1'b0, 5, 2, 1, 40);
  endtask

  task automatic t_polarity;
    run_check("R6 pol low", 0, 1'b0, 1'b0, 6, 4, 1, 24);
    run_check("R6 pol high", 2, 1'b0, 1'b1, 3, 2, 4, 36);
  endtask

  task automatic t_duty_ends;
    run_check("R7 duty zero", 0, 1'b0, 1'b1, 4, 0, 1, 16);
    run_check("R7 duty eq period", 0, 1'b0, 1'b1, 4, 4, 1, 16);
    run_check("R7 duty above period", 0, 1'b1, 1'b0, 3, 9, 1, 16);
  endtask

  task automatic t_dividers;
    wr(2'd3, {8'd3, 8'd5});
    run_check("R2 div A", 11, 1'b0, 1'b1, 4, 1, 5, 60);
    run_check("R2 div B", 12, 1'b1, 1'b1, 3, 2, 3, 60);
  endtask

  task automatic t_div_zero;
    wr(2'd3, {8'd3, 8'd0});
    ch_en = 1'b0;
    wr(2'd0, mode_word(11, 1'b0, 1'b1));
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    @(posedge clk); #2 ch_en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check("R3 zero ratio holds", wave, 1'b1);
    end
    ch_en = 1'b0;
  endtask

  task automatic t_shadow;
    logic e;
    ch_en = 1'b0;
    wr(2'd0, mode_word(0, 1'b0, 1'b1));
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd1);
    @(posedge clk); #2 ch_en = 1'b1;
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      e = (i < 8) ? model(i, 1, 4, 1, 1'b1, 1'b0) : model(i - 8, 1, 6, 3, 1'b1, 1'b0);
      check("R8 update at boundary", wave, e);
      if (i == 5) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd3; end
      if (i == 6) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd6; end
      if (i == 7) wr_en = 1'b0;
    end
    ch_en = 1'b0;
  endtask

  task automatic t_disable;
    run_check("R9 before stop", 0, 1'b0, 1'b1, 3, 3, 1, 6);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R9 stopped pol high", wave, 1'b0);
    end
    wr(2'd0, mode_word(0, 1'b0, 1'b0));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R9 stopped pol low", wave, 1'b1);
    end
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_pre: check("R9 reset idle", wave, 1'b1);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_center();
    t_polarity();
    t_duty_ends();
    t_dividers();
    t_div_zero();
    t_shadow();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule